// File: doc/BRIEF.md
# Half-Duplex Single-Wire Serial Transmitter with Turnaround Guard

This block is the transmit half of a clocked, half-duplex serial link that shares one data wire between two ends. One bit goes out per clock. A byte travels as a twelve-bit frame made of:

- a low start bit,
- the eight data bits, least significant first,
- an even-parity bit,
- two stop bits.

While the driver is enabled, the block drives the start, data and parity bits. Stop bits and idle bits are made by releasing the driver, and an external pull-up then holds the wire high.

A direction request moves the block from listening to transmitting. On each such turnaround, the block keeps the wire released for a guard interval before the first start bit. The interval is two mandatory idle bits plus an extra count chosen by a 3-bit setting. Frames sent back to back while the block is still transmitting follow each other with no gap beyond their own stop bits.

On every released bit during transmit activity, the block compares the sampled wire with the high level it expects. A low reading means another device is driving, and the block latches a collision flag that stays set until a clear pulse arrives.

Top module: `hdx_link_tx`

## Requirements
- R1: While reset is held and on the first cycle after it, line_oe=0, line_drv=1, tx_ready=0 and coll_flag=0.
- R2: After dir_tx rises from receive mode with a byte already offered, exactly 2+X released idle bits go out before the start bit. X is set by guard_sel: codes 0,1,2,3,4,5,6,7 give X = 128,64,32,16,8,4,2,0, and code 0 is the power-up choice of the configuring logic.
- R3: A frame is sent in this order: a start bit of 0, data bits 0 to 7, an even-parity bit equal to the XOR of the data, then two stop bits of 1.
- R4: line_oe is 1 only during the start, data and parity bits. Whenever line_oe is 0, line_drv is 1.
- R5: The start bit of a frame is on the wire in the cycle after the tx_valid/tx_ready handshake. tx_ready is raised during the last stop bit, so a following byte starts with no extra idle bit.
- R6: A byte offered while already in transmit mode and idle starts in the cycle after it is accepted. No guard interval is inserted.
- R7: coll_flag is set in the cycle after line_in reads 0 during a released bit of transmit activity (guard, idle wait or stop bit). A low line_in during driven bits has no effect.
- R8: coll_flag holds until a cycle with coll_clr=1 and no new collision. A new collision in the same cycle as coll_clr leaves the flag set.
- R9: If dir_tx drops during a frame, the frame still completes, tx_ready stays 0, and the block returns to receive mode. The next turnaround inserts the full guard again. If dir_tx drops during the guard interval, the guard restarts from the beginning.
- R10: tx_ready is 1 only while dir_tx=1, and only in the idle-wait state or during the last stop bit. It is never 1 while the driver is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one line bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_byte | input | DATA_W | Byte to transmit |
| tx_valid | input | 1 | tx_byte is offered |
| tx_ready | output | 1 | Block accepts tx_byte this cycle |
| dir_tx | input | 1 | 1 requests transmit mode, 0 receive mode |
| guard_sel | input | SEL_W | Extra guard-time code (see R2) |
| line_in | input | 1 | Sampled level of the shared wire |
| line_drv | output | 1 | Value driven onto the wire |
| line_oe | output | 1 | Driver enable for the wire |
| coll_flag | output | 1 | Sticky collision indication |
| coll_clr | input | 1 | Pulse that clears coll_flag |

## Verification
The bound checker watches four rules on every cycle:

- each handshake is followed at once by a start bit;
- tx_ready never coincides with a driven bit;
- every rise of the driver enable has at least two released bits before it;
- the collision flag rises only after a released low reading and falls only after a clear pulse.

Some behaviours only show up in the bench's scenarios. These are the exact guard length for each setting code, LSB-first bit order and parity, the restart of the guard after a direction drop, and the fact that a low wire during driven bits is ignored. The bench compares every line bit against a scoreboard queue and counts the idle cycles before each handshake.

// File: rtl/hdx_pkg.sv
// Shared types and frame constants for the half-duplex transmitter.
// Assumes a fixed frame of start + DATA_W data + parity + two stop bits.
package hdx_pkg;

    typedef enum logic [1:0] {
        ST_RX    = 2'd0,   // receive mode, driver released
        ST_GUARD = 2'd1,   // turnaround idle bits
        ST_WAIT  = 2'd2,   // transmit mode, waiting for a byte
        ST_FRAME = 2'd3    // shifting a frame onto the wire
    } tx_state_e;

    localparam int STOP_BITS = 2;
    localparam int OVERHEAD  = 2 + STOP_BITS;   // start + parity + stops

endpackage

// File: rtl/hdx_guard_timer.sv
// Turnaround guard counter. On load it takes MIN_IDLE-2 plus the extra
// count decoded from sel; while run is high it counts down to zero.
// done is high when the count is zero. The owner holds the guard state
// for (count+1) cycles, then spends one more idle cycle offering ready,
// which gives MIN_IDLE+extra released bits in total.
// Assumes MIN_IDLE >= 2. Code all-ones selects no extra bits; a lower
// code c selects 2**(2**SEL_W-1-c) extra bits.
module hdx_guard_timer #(
    parameter int SEL_W    = 3,
    parameter int MIN_IDLE = 2,
    localparam int MAX_SHIFT = (1 << SEL_W) - 1,
    localparam int CNT_W     = $clog2(MIN_IDLE + (1 << MAX_SHIFT) + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             done
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] extra;
    logic [CNT_W-1:0] load_val;

    // Decode the guard code into the count loaded at turnaround.
    always_comb begin
        if (sel == '1) begin
            extra = '0;
        end else begin
            extra = CNT_W'(1) << (SEL_W'(MAX_SHIFT) - sel);
        end
        load_val = extra + CNT_W'(MIN_IDLE - 2);
    end

    // Count register: load on turnaround, count down while guarding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (run && cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/hdx_frame_ser.sv
// Frame serializer. On load it builds the full frame together with a
// matching driver-enable pattern; while run is high both shift one
// place per cycle. Bit 0 of each pattern is the bit on the wire now.
// last flags the final stop bit. Assumes load has priority over run.
module hdx_frame_ser #(
    parameter int DATA_W = 8,
    localparam int FRAME_W = DATA_W + hdx_pkg::OVERHEAD,
    localparam int IDX_W   = $clog2(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              run,
    input  logic [DATA_W-1:0] data,
    output logic              bit_val,
    output logic              bit_oe,
    output logic              last
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] pat;
    logic [FRAME_W-1:0] oen;
    logic [IDX_W-1:0]   idx;

    // Pattern and enable shift registers plus the bit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat <= '1;
            oen <= '0;
            idx <= '0;
        end else if (load) begin
            pat <= {{hdx_pkg::STOP_BITS{1'b1}}, ^data, data, 1'b0};
            oen <= {{hdx_pkg::STOP_BITS{1'b0}}, {(DATA_W + 2){1'b1}}};
            idx <= '0;
        end else if (run && !last) begin
            pat <= {1'b1, pat[FRAME_W-1:1]};
            oen <= {1'b0, oen[FRAME_W-1:1]};
            idx <= idx + IDX_W'(1);
        end
    end

    assign bit_val = pat[0];
    assign bit_oe  = oen[0];
    assign last    = (idx == LAST_IDX);

endmodule

// File: rtl/hdx_coll_mon.sv
// Collision monitor. When watch is high the wire should read high; a
// low reading sets a sticky flag. clr drops the flag unless a new
// collision is seen in the same cycle.
module hdx_coll_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic watch,
    input  logic line_in,
    input  logic clr,
    output logic flag
);

    // Sticky flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (watch && !line_in) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/hdx_link_tx.sv
// Half-duplex single-wire transmitter top. Sequences receive mode, the
// turnaround guard, idle wait and frame transmission. Released bits
// (idle, guard, stop) leave line_oe low so a pull-up holds the wire
// high. Those bits are watched for collisions. Assumes one wire bit
// per clk and that line_in is already synchronised to clk.
module hdx_link_tx #(
    parameter int DATA_W   = 8,
    parameter int SEL_W    = 3,
    parameter int MIN_IDLE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              dir_tx,
    input  logic [SEL_W-1:0]  guard_sel,
    input  logic              line_in,
    output logic              line_drv,
    output logic              line_oe,
    output logic              coll_flag,
    input  logic              coll_clr
);

    import hdx_pkg::*;

    tx_state_e state, state_nx;
    logic      accept;
    logic      guard_done;
    logic      ser_bit, ser_oe, ser_last;
    logic      in_frame;

    assign in_frame = (state == ST_FRAME);
    assign tx_ready = dir_tx && ((state == ST_WAIT) || (in_frame && ser_last));
    assign accept   = tx_ready && tx_valid;

    // Next-state selection for the direction and frame sequencer.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RX:    if (dir_tx) state_nx = ST_GUARD;
            ST_GUARD: begin
                if (!dir_tx)         state_nx = ST_RX;
                else if (guard_done) state_nx = ST_WAIT;
            end
            ST_WAIT: begin
                if (accept)       state_nx = ST_FRAME;
                else if (!dir_tx) state_nx = ST_RX;
            end
            ST_FRAME: begin
                if (ser_last) begin
                    if (accept)      state_nx = ST_FRAME;
                    else if (dir_tx) state_nx = ST_WAIT;
                    else             state_nx = ST_RX;
                end
            end
            default: state_nx = ST_RX;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RX;
        else        state <= state_nx;
    end

    hdx_guard_timer #(
        .SEL_W    (SEL_W),
        .MIN_IDLE (MIN_IDLE)
    ) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .load  ((state == ST_RX) && dir_tx),
        .run   (state == ST_GUARD),
        .sel   (guard_sel),
        .done  (guard_done)
    );

    hdx_frame_ser #(
        .DATA_W (DATA_W)
    ) u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .run     (in_frame),
        .data    (tx_byte),
        .bit_val (ser_bit),
        .bit_oe  (ser_oe),
        .last    (ser_last)
    );

    // Wire drive: enable only on driven frame bits, park high otherwise.
    always_comb begin
        line_oe  = in_frame && ser_oe;
        line_drv = line_oe ? ser_bit : 1'b1;
    end

    hdx_coll_mon u_coll (
        .clk     (clk),
        .rst_n   (rst_n),
        .watch   ((state != ST_RX) && !line_oe),
        .line_in (line_in),
        .clr     (coll_clr),
        .flag    (coll_flag)
    );

endmodule

// File: rtl/hdx_link_tx_chk.sv
// Cycle-level rules for hdx_link_tx, attached with bind. It observes
// only the ports of the top module.
module hdx_link_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_valid,
    input logic tx_ready,
    input logic line_oe,
    input logic line_drv,
    input logic line_in,
    input logic coll_flag,
    input logic coll_clr
);

    // R5
    start_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (line_oe && !line_drv));

    // R10
    ready_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> !line_oe);

    // R2
    min_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_oe) |-> !$past(line_oe, 2));

    // R7
    coll_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coll_flag) |-> $past(!line_oe && !line_in));

    // R8
    coll_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_flag && !coll_clr) |=> coll_flag);

    // R8
    coll_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(coll_flag) |-> $past(coll_clr));

endmodule

bind hdx_link_tx hdx_link_tx_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .line_oe   (line_oe),
    .line_drv  (line_drv),
    .line_in   (line_in),
    .coll_flag (coll_flag),
    .coll_clr  (coll_clr)
);

// File: tb/test_hdx_link_tx.sv
// Scoreboard bench: stimulus tasks push the expected wire bit for each
// cycle into a queue, and a monitor pops and compares them in mid-cycle.
module test_hdx_link_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       dir_tx = 1'b0;
    logic [2:0] guard_sel = 3'd0;
    logic       line_in = 1'b1;
    logic       line_drv, line_oe, coll_flag;
    logic       coll_clr = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done_flag = 1'b0;
    logic [1:0] exp_q[$];   // {oe, drv}

    always #10 clk = ~clk;

    hdx_link_tx i_hdx_link_tx (
        .clk(clk), .rst_n(rst_n), .tx_byte(tx_byte), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .dir_tx(dir_tx), .guard_sel(guard_sel),
        .line_in(line_in), .line_drv(line_drv), .line_oe(line_oe),
        .coll_flag(coll_flag), .coll_clr(coll_clr)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int guard_len(input logic [2:0] s);
        return 2 + ((s == 3'd7) ? 0 : (1 << (7 - s)));
    endfunction

    task automatic push_frame(input logic [7:0] b);
        exp_q.push_back(2'b10);
        for (int i = 0; i < 8; i++) exp_q.push_back({1'b1, b[i]});
        exp_q.push_back({1'b1, ^b});
        exp_q.push_back(2'b01);
        exp_q.push_back(2'b01);
    endtask

    // Offer a byte, count negedges waited for ready, push its frame.
    task automatic send_byte(input logic [7:0] b, output int waited);
        waited = 0;
        tx_byte = b;
        tx_valid = 1'b1;
        while (!tx_ready) begin
            @(negedge clk);
            waited++;
        end
        push_frame(b);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic turn_and_send(input logic [2:0] s, input logic [7:0] b, input string req);
        int w;
        guard_sel = s;
        dir_tx = 1'b1;
        for (int i = 0; i < guard_len(s); i++) exp_q.push_back(2'b01);
        send_byte(b, w);
        check(req, w, guard_len(s));
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: compare each wire bit in mid-cycle; idle expected if queue empty.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (rst_n && !done_flag) begin
                logic [1:0] e;
                e = (exp_q.size() != 0) ? exp_q.pop_front() : 2'b01;
                check("R3/R4 line_oe", int'(line_oe), int'(e[1]));
                check("R3/R4 line_drv", int'(line_drv), int'(e[0]));
            end
        end
    end

    // Watchdog: an expired run counts as one failed check.
    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

    initial begin
        int w;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 oe", int'(line_oe), 0);
        check("R1 drv", int'(line_drv), 1);
        check("R1 ready", int'(tx_ready), 0);
        check("R1 coll", int'(coll_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 oe after", int'(line_oe), 0);
        check("R1 coll after", int'(coll_flag), 0);

        // R2 minimum guard, R3 frame order, then R5 back-to-back
        turn_and_send(3'd7, 8'hA5, "R2 guard code7");
        send_byte(8'h3C, w);
        check("R5 ready on last stop", w, 11);
        drain();
        // R6: byte in transmit idle starts without guard
        send_byte(8'hF0, w);
        check("R6 no guard in tx idle", w, 0);
        // R9: drop direction mid-frame
        dir_tx = 1'b0;
        for (int i = 0; i < 11; i++) begin
            check("R9/R10 ready low after drop", int'(tx_ready), 0);
            @(negedge clk);
        end
        drain();

        // R2 several guard codes, each after a fresh turnaround (R9)
        turn_and_send(3'd0, 8'h01, "R2 guard code0");
        dir_tx = 1'b0; drain();
        turn_and_send(3'd3, 8'h80, "R2 guard code3");
        dir_tx = 1'b0; drain();
        turn_and_send(3'd6, 8'h7E, "R2 guard code6");
        dir_tx = 1'b0; drain();

        // R9: direction dropped during guard restarts the guard
        guard_sel = 3'd0;
        dir_tx = 1'b1;
        repeat (5) @(negedge clk);
        check("R10 ready low in guard", int'(tx_ready), 0);
        dir_tx = 1'b0;
        repeat (2) @(negedge clk);
        turn_and_send(3'd6, 8'h55, "R9 guard restart");
        drain();

        // R7: collision in the idle wait (still in transmit mode)
        line_in = 1'b0;
        @(negedge clk);
        line_in = 1'b1;
        check("R7 coll on idle low", int'(coll_flag), 1);
        repeat (3) @(negedge clk);
        check("R8 coll holds", int'(coll_flag), 1);
        coll_clr = 1'b1;
        @(negedge clk);
        coll_clr = 1'b0;
        check("R8 coll cleared", int'(coll_flag), 0);
        line_in = 1'b0;
        coll_clr = 1'b1;
        @(negedge clk);
        line_in = 1'b1;
        coll_clr = 1'b0;
        check("R8 set wins over clear", int'(coll_flag), 1);
        coll_clr = 1'b1;
        @(negedge clk);
        coll_clr = 1'b0;

        // R7: low line during driven bits is ignored
        send_byte(8'h00, w);
        line_in = 1'b0;
        repeat (10) @(negedge clk);
        line_in = 1'b1;
        @(negedge clk);
        check("R7 no coll on driven bits", int'(coll_flag), 0);
        // R7: low line on a stop bit is caught
        send_byte(8'hC3, w);
        check("R5 next byte at last stop", w, 0);
        repeat (10) @(negedge clk);
        line_in = 1'b0;
        @(negedge clk);
        line_in = 1'b1;
        check("R7 coll on stop bit", int'(coll_flag), 1);
        dir_tx = 1'b0;
        drain();

        done_flag = 1'b1;
        report();
    end

endmodule